// File: doc/BRIEF.md
# RTC Event Flags, Watchdog and Interrupt Pin

This block collects the event status of a real-time clock in one flags byte and drives a shared interrupt pin from it. Alarm and power-fail events come in as single-cycle strobes. A loss of oscillator arrives as a level. An internal down-counting watchdog produces its own timeout event. The alarm, power-fail and watchdog flags are sticky. Reading the flags register returns their value and clears them.

Software reaches the block through a small byte-wide register port with three registers. The flags register is at address 0. The interrupt control register is at address 1 and holds one enable per source, the pin polarity and a pulse/level selection that is passed out to the pin driver. The watchdog reload is at address 2, and reading that address returns the live count. The interrupt pin is asserted while any enabled flag is set, at the programmed polarity. The watchdog counts down on an external one-tick timebase strobe.

Top module: `rtc_flag_irq`

## Requirements
- R1: The flags byte `flags_o` (also read at address 0) is laid out as follows: bit 7 watchdog, bit 6 alarm, bit 5 power-fail, bit 4 oscillator-fail, bit 3 always 0, bit 2 calibration mode, bit 1 write lock, bit 0 read lock.
- R2: After reset all flags, the control bits, the enables, the polarity, the pulse select and the watchdog count are 0, so `irq_o` is high (inactive, active low).
- R3: An `alarm_i` or `pfail_i` strobe sets bit 6 or bit 5, and the bit stays set until a flags read.
- R4: A read at address 0 (`rd_en_i`) puts the current flags on `rdata_o` one cycle later and, at the same edge, clears bits 7, 6 and 5. Bits 4 and 2:0 are not changed by the read.
- R5: An event strobe or a watchdog expiry in the same cycle as a clearing read leaves that flag set.
- R6: A write at address 2 loads the watchdog count from `wdata_i` and restarts the countdown. Each `tick_i` decrements a nonzero count. The step from 1 to 0 sets bit 7. The count holds at 0. A reload of 0 never sets the flag. A load takes priority over a tick in the same cycle.
- R7: Writes at address 0 cannot set or clear bits 7, 6 or 5.
- R8: Control register at address 1: bit 0 enables the watchdog source, bit 1 the alarm source, bit 2 the power-fail source. The pin is asserted exactly when some enabled source flag is set.
- R9: Control bit 3 selects the pin polarity: 0 makes `irq_o` active low, 1 makes it active high.
- R10: Control bit 4 is driven on `pulse_mode_o`. A read at address 1 returns the control register with bits 7:5 as 0.
- R11: `osc_fail_i` high sets bit 4. A write at address 0 with bit 4 = 0 clears it only while `osc_fail_i` is low, and writing 1 to bit 4 has no effect. A write at address 0 stores data bits 2:0 into flag bits 2:0.
- R12: A read at address 2 returns the current watchdog count, and a read at address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after rd_en_i |
| alarm_i | input | 1 | Alarm event strobe |
| pfail_i | input | 1 | Power-fail event strobe |
| osc_fail_i | input | 1 | Oscillator-fail level |
| tick_i | input | 1 | Watchdog timebase strobe |
| flags_o | output | 8 | Live flags byte |
| irq_o | output | 1 | Interrupt pin |
| pulse_mode_o | output | 1 | Pulse/level select for the pin driver |

## Verification
The hardest case to reach from the ports is a collision: an alarm strobe in the same cycle as the clearing read of the flags register. The read must return the old byte while the alarm survives the clear. The bench drives `alarm_i` and `rd_en_i` from one task in one cycle. It then checks the returned byte and the live flags separately. The watchdog is restarted partway through a countdown. The bench also checks that the extra ticks that would have expired the first load leave bit 7 clear.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned SRC_WD  = 0;
  localparam int unsigned SRC_AL  = 1;
  localparam int unsigned SRC_PF  = 2;

  localparam int unsigned FB_WD  = 7;
  localparam int unsigned FB_AL  = 6;
  localparam int unsigned FB_PF  = 5;
  localparam int unsigned FB_OSC = 4;

  typedef enum logic [1:0] {
    A_FLAGS = 2'd0,
    A_CTRL  = 2'd1,
    A_WDOG  = 2'd2,
    A_NONE  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic               pulse;
    logic               pol_high;
    logic [NUM_SRC-1:0] en;
  } irq_ctrl_t;
endpackage

// File: rtl/rtc_wdog.sv
module rtc_wdog #(
  parameter int unsigned WD_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [WD_W-1:0] load_val_i,
  input  logic            tick_i,
  output logic [WD_W-1:0] cnt_o,
  output logic            expire_o
);
  localparam logic [WD_W-1:0] ONE = WD_W'(1);

  logic [WD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (load_i)                      cnt_q <= load_val_i;
    else if (tick_i && (cnt_q != '0))     cnt_q <= cnt_q - ONE;
  end

  // load wins over a tick, so a reload right at expiry cancels it
  always_comb expire_o = tick_i && !load_i && (cnt_q == ONE);
  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
  import rtc_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               rd_clr_i,
  input  logic               osc_fail_i,
  input  logic               wr_i,
  input  logic [7:0]         wdata_i,
  output logic [NUM_SRC-1:0] ev_o,
  output logic [7:0]         flags_o
);
  logic [NUM_SRC-1:0] ev_q;
  logic               osc_q;
  logic [2:0]         ctl_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ev
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ev_q[i] <= 1'b0;
      else         ev_q[i] <= set_i[i] | (ev_q[i] & ~rd_clr_i);  // set wins
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_q <= 1'b0;
      ctl_q <= '0;
    end else begin
      osc_q <= osc_fail_i | (osc_q & ~(wr_i & ~wdata_i[FB_OSC]));
      if (wr_i) ctl_q <= wdata_i[2:0];
    end
  end

  always_comb begin
    flags_o         = '0;
    flags_o[FB_WD]  = ev_q[SRC_WD];
    flags_o[FB_AL]  = ev_q[SRC_AL];
    flags_o[FB_PF]  = ev_q[SRC_PF];
    flags_o[FB_OSC] = osc_q;
    flags_o[2:0]    = ctl_q;
  end

  assign ev_o = ev_q;
endmodule

// File: rtl/rtc_irq_pin.sv
module rtc_irq_pin
  import rtc_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               pol_high_i,
  output logic               irq_o
);
  logic active;
  always_comb begin
    active = |(en_i & src_i);
    irq_o  = pol_high_i ? active : ~active;
  end
endmodule

// File: rtl/rtc_flag_irq.sv
module rtc_flag_irq
  import rtc_irq_pkg::*;
#(
  parameter int unsigned WD_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       alarm_i,
  input  logic       pfail_i,
  input  logic       osc_fail_i,
  input  logic       tick_i,
  output logic [7:0] flags_o,
  output logic       irq_o,
  output logic       pulse_mode_o
);
  localparam int unsigned CTRL_W = $bits(irq_ctrl_t);

  logic               wr_flags, wr_ctrl, wd_load, rd_flags, wd_exp;
  logic [WD_W-1:0]    wd_cnt;
  logic [NUM_SRC-1:0] ev_set, ev;
  irq_ctrl_t          ctrl_q;
  logic [7:0]         rd_mux;

  always_comb begin
    wr_flags = wr_en_i && (addr_i == A_FLAGS);
    wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
    wd_load  = wr_en_i && (addr_i == A_WDOG);
    rd_flags = rd_en_i && (addr_i == A_FLAGS);
    ev_set           = '0;
    ev_set[SRC_WD]   = wd_exp;
    ev_set[SRC_AL]   = alarm_i;
    ev_set[SRC_PF]   = pfail_i;
  end

  rtc_wdog #(.WD_W(WD_W)) u_wdog (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wd_load),
    .load_val_i (WD_W'(wdata_i)),
    .tick_i     (tick_i),
    .cnt_o      (wd_cnt),
    .expire_o   (wd_exp)
  );

  rtc_flag_bank u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (ev_set),
    .rd_clr_i   (rd_flags),
    .osc_fail_i (osc_fail_i),
    .wr_i       (wr_flags),
    .wdata_i    (wdata_i),
    .ev_o       (ev),
    .flags_o    (flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= irq_ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  rtc_irq_pin u_pin (
    .en_i       (ctrl_q.en),
    .src_i      (ev),
    .pol_high_i (ctrl_q.pol_high),
    .irq_o      (irq_o)
  );

  assign pulse_mode_o = ctrl_q.pulse;

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      A_FLAGS: rd_mux = flags_o;
      A_CTRL:  rd_mux = 8'(ctrl_q);
      A_WDOG:  rd_mux = 8'(wd_cnt);
      default: rd_mux = '0;
    endcase
  end

  // read data captured at the same edge the sticky flags clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/rtc_flag_irq_chk.sv
module rtc_flag_irq_chk #(
  parameter int unsigned WD_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rd_en_i,
  input logic [1:0]      addr_i,
  input logic            alarm_i,
  input logic            pfail_i,
  input logic [7:0]      flags_o,
  input logic [WD_W-1:0] wd_cnt,
  input logic            wd_load
);
  a_r3_alarm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[6] && !(rd_en_i && addr_i == 2'd0)) |=> flags_o[6]);

  a_r4_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd0 && !alarm_i) |=> !flags_o[6]);

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_i || pfail_i) |=> (flags_o[6] || !alarm_i) && flags_o[5] == 1'b1 || !pfail_i && flags_o[6]);

  a_r7_no_write_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flags_o[5] && !pfail_i) |=> !flags_o[5]);

  a_r6_count_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_cnt == '0 && !wd_load) |=> wd_cnt == '0);

  a_r6_flag_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[7]) |-> $past(wd_cnt) == WD_W'(1));
endmodule

bind rtc_flag_irq rtc_flag_irq_chk #(.WD_W(WD_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .alarm_i (alarm_i),
  .pfail_i (pfail_i),
  .flags_o (flags_o),
  .wd_cnt  (wd_cnt),
  .wd_load (wd_load)
);

// File: tb/rtc_flag_irq_test.sv
module rtc_flag_irq_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, flags_o;
  logic       alarm_i = 1'b0, pfail_i = 1'b0, osc_fail_i = 1'b0, tick_i = 1'b0;
  logic       irq_o, pulse_mode_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic mon_pend = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  rtc_flag_irq uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .alarm_i(alarm_i), .pfail_i(pfail_i), .osc_fail_i(osc_fail_i), .tick_i(tick_i),
    .flags_o(flags_o), .irq_o(irq_o), .pulse_mode_o(pulse_mode_o)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when the design returns it
  always @(posedge clk) mon_pend <= rd_en_i;
  always @(negedge clk) begin
    if (mon_pend && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rdata_o == e, t, rdata_o, e);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t, input bit with_alarm = 1'b0);
    addr_i = a; rd_en_i = 1'b1; alarm_i = with_alarm;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en_i = 1'b0; alarm_i = 1'b0;
  endtask

  task automatic ev(input bit al, input bit pf, input bit osc, input bit tk);
    alarm_i = al; pfail_i = pf; osc_fail_i = osc; tick_i = tk;
    @(negedge clk);
    alarm_i = 1'b0; pfail_i = 1'b0; osc_fail_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog timeout");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(flags_o == 8'h00, "R2 flags after reset", flags_o, 8'h00);
    check(irq_o == 1'b1, "R2 pin inactive after reset", {7'd0, irq_o}, 8'h01);
    check(pulse_mode_o == 1'b0, "R2 pulse select after reset", {7'd0, pulse_mode_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);

    ev(1, 0, 0, 0);
    check(flags_o == 8'h40, "R3 R1 alarm flag bit 6", flags_o, 8'h40);
    check(irq_o == 1'b1, "R8 disabled source keeps pin idle", {7'd0, irq_o}, 8'h01);
    repeat (2) @(negedge clk);
    check(flags_o == 8'h40, "R3 alarm flag sticky", flags_o, 8'h40);

    wr(2'd1, 8'h02);
    check(irq_o == 1'b0, "R8 R9 alarm enabled active low", {7'd0, irq_o}, 8'h00);
    wr(2'd1, 8'h0A);
    check(irq_o == 1'b1, "R9 active high polarity", {7'd0, irq_o}, 8'h01);

    rd(2'd0, 8'h40, "R4 read returns flags");
    check(flags_o == 8'h00, "R4 read clears alarm", flags_o, 8'h00);
    check(irq_o == 1'b0, "R9 active high idle", {7'd0, irq_o}, 8'h00);

    ev(0, 1, 0, 0);
    wr(2'd0, 8'hFF);
    check(flags_o == 8'h27, "R7 R11 write cannot touch event bits", flags_o, 8'h27);
    check(irq_o == 1'b0, "R8 unenabled power-fail ignored", {7'd0, irq_o}, 8'h00);

    ev(0, 0, 1, 0);
    check(flags_o == 8'h37, "R11 osc flag set", flags_o, 8'h37);
    wr(2'd0, 8'h07);
    check(flags_o == 8'h27, "R11 osc flag cleared by write", flags_o, 8'h27);

    rd(2'd0, 8'h27, "R5 read data before collision", 1'b1);
    check(flags_o == 8'h47, "R5 alarm survives clearing read", flags_o, 8'h47);

    wr(2'd2, 8'd3);
    rd(2'd2, 8'd3, "R12 watchdog count readback");
    ev(0, 0, 0, 1);
    ev(0, 0, 0, 1);
    check(flags_o[7] == 1'b0, "R6 no flag before zero", flags_o, 8'h47);
    ev(0, 0, 0, 1);
    check(flags_o == 8'hC7, "R6 watchdog flag on expiry", flags_o, 8'hC7);
    ev(0, 0, 0, 1);
    rd(2'd2, 8'd0, "R6 count holds at zero");

    wr(2'd1, 8'h01);
    check(irq_o == 1'b0, "R8 watchdog source active low", {7'd0, irq_o}, 8'h00);
    wr(2'd1, 8'h11);
    check(pulse_mode_o == 1'b1, "R10 pulse select output", {7'd0, pulse_mode_o}, 8'h01);
    rd(2'd1, 8'h11, "R10 control readback");

    rd(2'd0, 8'hC7, "R4 read with watchdog flag");
    check(flags_o == 8'h07, "R4 bits 7:5 cleared, others kept", flags_o, 8'h07);
    check(irq_o == 1'b1, "R8 pin released after clear", {7'd0, irq_o}, 8'h01);

    wr(2'd2, 8'd0);
    repeat (3) ev(0, 0, 0, 1);
    check(flags_o == 8'h07, "R6 zero reload never expires", flags_o, 8'h07);

    wr(2'd2, 8'd5);
    repeat (2) ev(0, 0, 0, 1);
    wr(2'd2, 8'd5);
    repeat (4) ev(0, 0, 0, 1);
    check(flags_o == 8'h07, "R6 reload restarts countdown", flags_o, 8'h07);
    ev(0, 0, 0, 1);
    check(flags_o == 8'h87, "R6 expiry after restart", flags_o, 8'h87);
    check(irq_o == 1'b0, "R8 watchdog drives pin", {7'd0, irq_o}, 8'h00);

    rd(2'd3, 8'h00, "R12 unused address reads zero");
    @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R4 read results missing actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    summary();
  end
endmodule